// File: doc/BRIEF.md
# Glyph Outline and Drop-Shadow Dot Generator

This block sits between the font lookup and the colour mixer of an on-screen overlay. For every character cell it takes three font rows at once: the scan line being drawn, the one above it and the one below it. It also takes the single boundary dot of the cell to the left and the single boundary dot of the cell to the right. From these it emits two flags per dot on a dot clock: a glyph flag and an edge flag. Downstream logic paints the edge flag in black, which keeps text readable over backgrounds of a similar colour.

Cells sit edge to edge with no spacing between them. The left and right neighbour dots therefore let an outline continue across a cell boundary. Two qualifier inputs report whether the row above and the row below are real font data. When they are not, the block treats those rows as empty.

Edge drawing has two styles. The outline style rings the glyph on all four sides. The drop-shadow style marks only the dots to the right of and below the glyph. A strobe loads a new cell's data. The dots then leave the block leftmost first, one per clock.

Top module: `osd_edge_gen`

## Requirements
- R1: While reset is asserted, and after its release until the first cell strobe, both `fgDot` and `edgeDot` are 0.
- R2: A cell strobe sampled at clock edge E loads the row. Dot k of the cell (k=0 is `rowCur[9]`, the leftmost dot; k=9 is `rowCur[0]`) appears on the outputs after edge E+1+k. `fgDot` equals that font bit.
- R3: When `edgeEn` was 0 at the strobe, `edgeDot` stays 0 for the whole cell, and `fgDot` still follows the font.
- R4: In outline style (`shadowSel`=0 at the strobe), `edgeDot` is 1 exactly on a background dot that has a glyph dot directly left, right, above or below it.
- R5: In drop-shadow style (`shadowSel`=1 at the strobe), `edgeDot` is 1 exactly on a background dot that has a glyph dot directly left of it or directly above it. Glyph dots to its right or below it have no effect.
- R6: A glyph dot never carries an edge. `fgDot` and `edgeDot` are never both 1.
- R7: For dot 0, `leftNbr` stands in as the left neighbour. For dot 9, `rightNbr` stands in as the right neighbour.
- R8: When `aboveValid` is 0 at the strobe, `rowPrev` is treated as all background. When `belowValid` is 0, `rowNext` is treated as all background.
- R9: If no new strobe arrives, both outputs return to 0 from edge E+11 onward, after the ten dots of the cell.
- R10: A strobe that arrives in the middle of a cell abandons the rest of that cell. The new cell's dot 0 appears after the following edge.
- R11: Changes of `edgeEn` and `shadowSel` between strobes have no effect on the cell in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dotClk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cellStart | input | 1 | Loads a new cell's rows and settings |
| rowPrev | input | 10 | Font row of the scan line above |
| rowCur | input | 10 | Font row of the scan line being drawn, bit 9 leftmost |
| rowNext | input | 10 | Font row of the scan line below |
| leftNbr | input | 1 | Rightmost dot of the left neighbour cell, current line |
| rightNbr | input | 1 | Leftmost dot of the right neighbour cell, current line |
| aboveValid | input | 1 | rowPrev holds real font data |
| belowValid | input | 1 | rowNext holds real font data |
| edgeEn | input | 1 | Enables edge generation |
| shadowSel | input | 1 | 1 selects drop-shadow style, 0 selects outline style |
| fgDot | output | 1 | Glyph dot flag |
| edgeDot | output | 1 | Edge dot flag |

## Verification
Two things can want the same dot in one cycle. The glyph test and the edge test can both claim it. A cell restart can also land on the very edge where the previous cell would have shifted. The bench provokes the first case with fully lit rows whose neighbours are lit as well, and with alternating dots that place glyph and edge side by side. It judges the result dot by dot against the priority rule. For the restart, a second strobe is issued four dots into a solid cell. The bench then expects the old cell's fifth dot, followed at once by the new cell's first dot.

// File: rtl/osd_edge_pkg.sv
package osd_edge_pkg;

  // Strobes handed from the sequencer to the dot datapath
  typedef struct packed {
    logic load;    // capture a new cell this edge
    logic shift;   // advance to the next dot this edge
    logic active;  // the dot window holds a valid dot
  } ctlStrobes_t;

endpackage

// File: rtl/osd_edge_ctl.sv
module osd_edge_ctl
  import osd_edge_pkg::*;
#(
  parameter int CELL_W = 10
) (
  input  logic        dotClk,
  input  logic        rstN,
  input  logic        cellStart,
  output ctlStrobes_t strb
);

  localparam int CNT_W = $clog2(CELL_W);
  localparam logic [CNT_W-1:0] LAST_DOT = CNT_W'(CELL_W - 1);

  logic             active;
  logic [CNT_W-1:0] dotCnt;

  always_ff @(posedge dotClk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      dotCnt <= '0;
    end else if (cellStart) begin
      active <= 1'b1;
      dotCnt <= '0;
    end else if (active) begin
      if (dotCnt == LAST_DOT) begin
        active <= 1'b0;
        dotCnt <= '0;
      end else begin
        dotCnt <= dotCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load   = cellStart;
    strb.shift  = active && !cellStart;
    strb.active = active;
  end

  // R9
  cnt_range_chk: assert property (@(posedge dotClk) disable iff (!rstN)
    active |-> (dotCnt <= LAST_DOT));

  // R10
  restart_chk: assert property (@(posedge dotClk) disable iff (!rstN)
    cellStart |=> (active && dotCnt == '0));

endmodule

// File: rtl/osd_edge_dp.sv
module osd_edge_dp
  import osd_edge_pkg::*;
#(
  parameter int CELL_W = 10
) (
  input  logic              dotClk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [CELL_W-1:0] rowPrev,
  input  logic [CELL_W-1:0] rowCur,
  input  logic [CELL_W-1:0] rowNext,
  input  logic              leftNbr,
  input  logic              rightNbr,
  input  logic              aboveValid,
  input  logic              belowValid,
  input  logic              edgeEn,
  input  logic              shadowSel,
  output logic              fgDot,
  output logic              edgeDot
);

  localparam int EXT_W = CELL_W + 2;

  // Current row with one boundary dot on each side
  logic [EXT_W-1:0]  curSh;
  logic [CELL_W-1:0] prevSh;
  logic [CELL_W-1:0] nextSh;
  logic              enQ;
  logic              shadowQ;

  always_ff @(posedge dotClk or negedge rstN) begin
    if (!rstN) begin
      curSh   <= '0;
      prevSh  <= '0;
      nextSh  <= '0;
      enQ     <= 1'b0;
      shadowQ <= 1'b0;
    end else if (strb.load) begin
      curSh   <= {leftNbr, rowCur, rightNbr};
      prevSh  <= aboveValid ? rowPrev : '0;
      nextSh  <= belowValid ? rowNext : '0;
      enQ     <= edgeEn;
      shadowQ <= shadowSel;
    end else if (strb.shift) begin
      curSh   <= {curSh[EXT_W-2:0], 1'b0};
      prevSh  <= {prevSh[CELL_W-2:0], 1'b0};
      nextSh  <= {nextSh[CELL_W-2:0], 1'b0};
    end
  end

  // Neighbourhood of the dot now at the window
  logic nLeft, nCenter, nRight, nUp, nDown;
  logic nearGlyph, edgeNow;

  always_comb begin
    nLeft   = curSh[EXT_W-1];
    nCenter = curSh[EXT_W-2];
    nRight  = curSh[EXT_W-3];
    nUp     = prevSh[CELL_W-1];
    nDown   = nextSh[CELL_W-1];
    if (shadowQ) nearGlyph = nLeft | nUp;
    else         nearGlyph = nLeft | nRight | nUp | nDown;
    edgeNow = enQ && !nCenter && nearGlyph;
  end

  always_ff @(posedge dotClk or negedge rstN) begin
    if (!rstN) begin
      fgDot   <= 1'b0;
      edgeDot <= 1'b0;
    end else begin
      fgDot   <= strb.active && nCenter;
      edgeDot <= strb.active && edgeNow;
    end
  end

  // R6
  edge_excl_chk: assert property (@(posedge dotClk) disable iff (!rstN)
    !(fgDot && edgeDot));

  // R3
  en_off_chk: assert property (@(posedge dotClk) disable iff (!rstN)
    !enQ |=> !edgeDot);

  // R5
  shadow_side_chk: assert property (@(posedge dotClk) disable iff (!rstN)
    (shadowQ && !curSh[EXT_W-1] && !prevSh[CELL_W-1]) |=> !edgeDot);

  // R9
  idle_quiet_chk: assert property (@(posedge dotClk) disable iff (!rstN)
    !strb.active |=> (!fgDot && !edgeDot));

endmodule

// File: rtl/osd_edge_gen.sv
module osd_edge_gen
  import osd_edge_pkg::*;
#(
  parameter int CELL_W = 10
) (
  input  logic              dotClk,
  input  logic              rstN,
  input  logic              cellStart,
  input  logic [CELL_W-1:0] rowPrev,
  input  logic [CELL_W-1:0] rowCur,
  input  logic [CELL_W-1:0] rowNext,
  input  logic              leftNbr,
  input  logic              rightNbr,
  input  logic              aboveValid,
  input  logic              belowValid,
  input  logic              edgeEn,
  input  logic              shadowSel,
  output logic              fgDot,
  output logic              edgeDot
);

  ctlStrobes_t strb;

  osd_edge_ctl #(.CELL_W(CELL_W)) i_ctl (
    .dotClk    (dotClk),
    .rstN      (rstN),
    .cellStart (cellStart),
    .strb      (strb)
  );

  osd_edge_dp #(.CELL_W(CELL_W)) i_dp (
    .dotClk     (dotClk),
    .rstN       (rstN),
    .strb       (strb),
    .rowPrev    (rowPrev),
    .rowCur     (rowCur),
    .rowNext    (rowNext),
    .leftNbr    (leftNbr),
    .rightNbr   (rightNbr),
    .aboveValid (aboveValid),
    .belowValid (belowValid),
    .edgeEn     (edgeEn),
    .shadowSel  (shadowSel),
    .fgDot      (fgDot),
    .edgeDot    (edgeDot)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge dotClk)
    !rstN |=> (!fgDot && !edgeDot));

endmodule

// File: tb/test_osd_edge_gen.sv
module test_osd_edge_gen;

  logic       dotClk = 1'b0;
  logic       rstN = 1'b0;
  logic       cellStart = 1'b0;
  logic [9:0] rowPrev = '0, rowCur = '0, rowNext = '0;
  logic       leftNbr = 1'b0, rightNbr = 1'b0;
  logic       aboveValid = 1'b1, belowValid = 1'b1;
  logic       edgeEn = 1'b0, shadowSel = 1'b0;
  logic       fgDot, edgeDot;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 dotClk = ~dotClk;

  osd_edge_gen i_osd_edge_gen (
    .dotClk(dotClk), .rstN(rstN), .cellStart(cellStart),
    .rowPrev(rowPrev), .rowCur(rowCur), .rowNext(rowNext),
    .leftNbr(leftNbr), .rightNbr(rightNbr),
    .aboveValid(aboveValid), .belowValid(belowValid),
    .edgeEn(edgeEn), .shadowSel(shadowSel),
    .fgDot(fgDot), .edgeDot(edgeDot)
  );

  // Vector fields: {req[3:0], prev, cur, next, l, r, av, bv, en, sh, expFg, expEdge}
  localparam int NV = 12;
  localparam logic [59:0] VECS [NV] = '{
    {4'd4,  10'h000, 10'h030, 10'h000, 6'b001110, 10'h030, 10'h048}, // R4 sides
    {4'd5,  10'h000, 10'h030, 10'h000, 6'b001111, 10'h030, 10'h008}, // R5 right only
    {4'd4,  10'h201, 10'h000, 10'h020, 6'b001110, 10'h000, 10'h221}, // R4 up/down
    {4'd5,  10'h201, 10'h000, 10'h020, 6'b001111, 10'h000, 10'h201}, // R5 above only
    {4'd5,  10'h000, 10'h000, 10'h020, 6'b001111, 10'h000, 10'h000}, // R5 below ignored
    {4'd8,  10'h201, 10'h000, 10'h020, 6'b000110, 10'h000, 10'h020}, // R8 above invalid
    {4'd7,  10'h000, 10'h000, 10'h000, 6'b111110, 10'h000, 10'h201}, // R7 both borders
    {4'd7,  10'h000, 10'h000, 10'h000, 6'b111111, 10'h000, 10'h200}, // R7 shadow left
    {4'd3,  10'h3FF, 10'h030, 10'h000, 6'b001100, 10'h030, 10'h000}, // R3 disabled
    {4'd6,  10'h3FF, 10'h3FF, 10'h3FF, 6'b111110, 10'h3FF, 10'h000}, // R6 solid
    {4'd2,  10'h000, 10'h2AA, 10'h000, 6'b001111, 10'h2AA, 10'h155}, // R2 alternating
    {4'd8,  10'h000, 10'h000, 10'h020, 6'b001010, 10'h000, 10'h000}  // R8 below invalid
  };

  task automatic chk(input string req, input logic actF, input logic actE,
                     input logic expF, input logic expE);
    total++;
    if (actF !== expF || actE !== expE) begin
      bad++;
      $display("FAIL %s: fg/edge=%b%b expected %b%b at t=%0t",
               req, actF, actE, expF, expE, $time);
    end
  endtask

  task automatic loadCell(input logic [9:0] p, input logic [9:0] c, input logic [9:0] n,
                          input logic [5:0] flags);
    rowPrev = p; rowCur = c; rowNext = n;
    {leftNbr, rightNbr, aboveValid, belowValid, edgeEn, shadowSel} = flags;
    cellStart = 1'b1;
  endtask

  always @(posedge dotClk) begin
    cycles++;
    if (cycles == 200000) begin
      bad++; total++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet in and after reset
    repeat (3) @(negedge dotClk);
    chk("R1", fgDot, edgeDot, 1'b0, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge dotClk);
    chk("R1", fgDot, edgeDot, 1'b0, 1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [59:0] e;
      string req;
      e = VECS[v];
      req = $sformatf("R%0d", e[59:56]);
      @(negedge dotClk);
      loadCell(e[55:46], e[45:36], e[35:26], e[25:20]);
      @(negedge dotClk);
      cellStart = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge dotClk);
        chk(req, fgDot, edgeDot, e[19-k], e[9-k]);
      end
    end

    // R9: one edge past the last dot the outputs fall back to background
    @(negedge dotClk);
    chk("R9", fgDot, edgeDot, 1'b0, 1'b0);

    // R10: restart four dots into a solid cell
    loadCell(10'h000, 10'h3FF, 10'h000, 6'b001110);
    @(negedge dotClk);
    cellStart = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge dotClk);
      chk("R10", fgDot, edgeDot, 1'b1, 1'b0);
    end
    loadCell(10'h000, 10'h000, 10'h000, 6'b001110);
    @(negedge dotClk);
    cellStart = 1'b0;
    chk("R10", fgDot, edgeDot, 1'b1, 1'b0);  // old dot 4
    @(negedge dotClk);
    chk("R10", fgDot, edgeDot, 1'b0, 1'b0);  // new dot 0
    repeat (10) @(negedge dotClk);

    // R11: settings changed mid-cell are ignored (outline kept at dot 3)
    loadCell(10'h000, 10'h030, 10'h000, 6'b001110);
    @(negedge dotClk);
    cellStart = 1'b0;
    edgeEn = 1'b0;
    shadowSel = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge dotClk);
      chk("R11", fgDot, edgeDot, (k == 4 || k == 5), (k == 3 || k == 6));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule